// File: doc/BRIEF.md
# Rotating-Slot Shared Memory Arbiter

This block lets a set of processor cores share one byte-addressable memory without any request priority. A free-running slot counter walks through a fixed rotation, and each core owns one short window in every turn of it. A core raises its request with an address, write data, a transfer size and a write flag, and holds them until it gets a one-cycle completion strobe. The arbiter serves that request only in the core's own window, so the wait depends only on where the counter stands when the request appears. It does not depend on the other cores.

The lower half of the 64 KB address space is read-write RAM and the upper half is a computed read-only region. Byte, word and long transfers are supported, and word and long addresses are forced onto their natural boundaries. The cores do not need to run in lock-step: a request may appear in any clock cycle, at any phase relative to the rotation. The arbiter drives at most one memory transaction per clock.

Top module: `rr_mem_arbiter`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `coreDone` is all zero and `coreRdata` is zero.
- R2: The slot counter is 4 bits wide and starts at 0 in the first clock after reset. It advances by one every clock, so the rotation repeats every 16 clocks. Core n owns the clock in which the counter equals 2n, and no core owns the odd counts.
- R3: A request is served only at the clock edge that ends its owner's window. `coreDone[n]` is high for exactly the one cycle after that edge. It is never high for a core that was not served, and at most one bit of `coreDone` is high in any cycle.
- R4: Suppose a request first appears in a cycle where the counter holds s. Its completion strobe is then seen ((2n - s) mod 16) + 1 cycles later, which is between 1 and 16 cycles.
- R5: A core may reissue in the cycle where it sees its strobe. It is then served again in its next window, so its strobes are exactly 16 cycles apart.
- R6: The size code selects the transfer: 0 is byte, 1 is word (16 bits), and 2 or 3 is long (32 bits). Bytes are little-endian: address a+k maps to bits [8k+7:8k]. Read data is zero-extended into `coreRdata`.
- R7: Word accesses clear address bit 0 and long accesses clear address bits 1:0 before the memory is addressed.
- R8: Addresses 0x0000 to 0x7FFF are RAM and 0x8000 to 0xFFFF are read-only. The byte at a read-only address a equals a[7:0] XOR a[15:8].
- R9: A write into the read-only half changes nothing, yet it still gets its completion strobe.
- R10: The RAM half is backed by RAM_BYTES bytes (default 4096). A RAM address selects the byte at (address mod RAM_BYTES), so higher RAM addresses alias it.
- R11: `coreRdata` shows 0 in the strobe cycle of a write. It holds its last value in every cycle in which no access completed.
- R12: When several cores request at once, whatever their phases, they are served in rotation order, each in its own window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| coreReq | input | NUM_CORES | Request, held high by each core until its strobe |
| coreWe | input | NUM_CORES | 1 = write, 0 = read, per core |
| coreSize | input | 2*NUM_CORES | Size code per core, core n at bits [2n+1:2n] |
| coreAddr | input | 16*NUM_CORES | Byte address per core |
| coreWdata | input | 32*NUM_CORES | Write data per core |
| coreDone | output | NUM_CORES | One-cycle completion strobe, one bit per core |
| coreRdata | output | 32 | Read data of the access that just completed |

## Verification
The hardest case to reach is a core that reissues in the very cycle it sees its strobe while every other core is also busy. The window has just closed, so the reissued request must wait the full 16 cycles, and a late mistake would drop a slot. The stimulus starts by filling the RAM from all eight cores at once with zero gaps. Directed sequences then target alignment, aliasing and writes to the read-only half. Random gaps finally place requests at every phase of the rotation, and the expected strobe cycle of each one is computed from the phase at which it was issued.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_LONG2 = 2'd3
  } accSize_t;

  // strobes from the slot control to the memory datapath
  typedef struct packed {
    logic access;
    logic write;
  } memStrobe_t;
endpackage

// File: rtl/arb_slot_ctrl.sv
module arb_slot_ctrl #(
  parameter int NUM_CORES = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CORES-1:0]         coreReq,
  input  logic [NUM_CORES-1:0]         coreWe,
  output logic [$clog2(NUM_CORES)-1:0] ownerIdx,
  output arb_pkg::memStrobe_t          strobe,
  output logic [NUM_CORES-1:0]         coreDone
);
  localparam int IDX_W  = $clog2(NUM_CORES);
  localparam int SLOT_W = IDX_W + 1;

  logic [SLOT_W-1:0]    slotCnt;
  logic [NUM_CORES-1:0] doneQ;
  logic                 windowOpen;
  logic                 grant;

  always_ff @(posedge clk) begin
    if (!rstN) slotCnt <= '0;
    else       slotCnt <= slotCnt + SLOT_W'(1);
  end

  assign ownerIdx   = slotCnt[SLOT_W-1:1];
  assign windowOpen = ~slotCnt[0];
  assign grant      = rstN && windowOpen && coreReq[ownerIdx];

  always_comb begin
    strobe.access = grant;
    strobe.write  = grant && coreWe[ownerIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= '0;
    else begin
      doneQ <= '0;
      if (grant) doneQ[ownerIdx] <= 1'b1;
    end
  end

  assign coreDone = doneQ;

  // R3: never more than one completion strobe
  assert_done_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(coreDone));

  // R2: windows are two clocks apart, so strobes never come back to back
  assert_done_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|coreDone) |=> !(|coreDone));

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_ownerChk
    // R3: a strobe only follows a held request in that core's own window
    assert_done_owner_R3: assert property (@(posedge clk) disable iff (!rstN)
      coreDone[i] |-> ($past(coreReq[i]) && $past(slotCnt) == SLOT_W'(2 * i)));
  end
endmodule

// File: rtl/arb_mem_datapath.sv
module arb_mem_datapath #(
  parameter int NUM_CORES = 8,
  parameter int RAM_BYTES = 4096
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  arb_pkg::memStrobe_t                 strobe,
  input  logic [$clog2(NUM_CORES)-1:0]        ownerIdx,
  input  logic [2*NUM_CORES-1:0]              coreSize,
  input  logic [arb_pkg::ADDR_W*NUM_CORES-1:0] coreAddr,
  input  logic [arb_pkg::DATA_W*NUM_CORES-1:0] coreWdata,
  output logic [arb_pkg::DATA_W-1:0]          coreRdata
);
  import arb_pkg::*;
  localparam int RAM_LONGS = RAM_BYTES / 4;
  localparam int LIDX_W    = $clog2(RAM_LONGS);

  logic [DATA_W-1:0] ramMem [RAM_LONGS];
  accSize_t          selSize;
  logic [ADDR_W-1:0] selAddr, alignedAddr;
  logic [DATA_W-1:0] selWdata, wLane, romWord, srcWord, shifted, readVal;
  logic [3:0]        byteEn;
  logic [1:0]        lane;
  logic [LIDX_W-1:0] ramIdx;
  logic              isRom;
  logic [DATA_W-1:0] rdataQ;

  assign selSize  = accSize_t'(coreSize[2*ownerIdx +: 2]);
  assign selAddr  = coreAddr[ADDR_W*ownerIdx +: ADDR_W];
  assign selWdata = coreWdata[DATA_W*ownerIdx +: DATA_W];

  always_comb begin
    unique case (selSize)
      SZ_BYTE: alignedAddr = selAddr;
      SZ_WORD: alignedAddr = {selAddr[ADDR_W-1:1], 1'b0};
      default: alignedAddr = {selAddr[ADDR_W-1:2], 2'b00};
    endcase
  end

  assign isRom  = alignedAddr[ADDR_W-1];
  assign lane   = alignedAddr[1:0];
  assign ramIdx = alignedAddr[LIDX_W+1:2];

  always_comb begin
    unique case (selSize)
      SZ_BYTE: begin
        byteEn = 4'b0001 << lane;
        wLane  = {4{selWdata[7:0]}};
      end
      SZ_WORD: begin
        byteEn = lane[1] ? 4'b1100 : 4'b0011;
        wLane  = {2{selWdata[15:0]}};
      end
      default: begin
        byteEn = 4'b1111;
        wLane  = selWdata;
      end
    endcase
  end

  // read-only content: low address byte XOR high address byte
  always_comb begin
    for (int b = 0; b < 4; b++) begin
      logic [ADDR_W-1:0] byteAddr;
      byteAddr = {alignedAddr[ADDR_W-1:2], 2'(b)};
      romWord[8*b +: 8] = byteAddr[7:0] ^ byteAddr[15:8];
    end
  end

  assign srcWord = isRom ? romWord : ramMem[ramIdx];
  assign shifted = srcWord >> {lane, 3'b000};

  always_comb begin
    unique case (selSize)
      SZ_BYTE: readVal = {24'd0, shifted[7:0]};
      SZ_WORD: readVal = {16'd0, shifted[15:0]};
      default: readVal = srcWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobe.write && !isRom) begin
      for (int b = 0; b < 4; b++)
        if (byteEn[b]) ramMem[ramIdx][8*b +: 8] <= wLane[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdataQ <= '0;
    else if (strobe.access) rdataQ <= strobe.write ? '0 : readVal;
  end

  assign coreRdata = rdataQ;

  // R11: read data only moves when an access was taken
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.access) |-> $stable(rdataQ));

  // R9: the control never asks for a write outside a granted window
  assert_write_in_window_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.write |-> strobe.access);
endmodule

// File: rtl/rr_mem_arbiter.sv
module rr_mem_arbiter #(
  parameter int NUM_CORES = 8,
  parameter int RAM_BYTES = 4096
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NUM_CORES-1:0]                 coreReq,
  input  logic [NUM_CORES-1:0]                 coreWe,
  input  logic [2*NUM_CORES-1:0]               coreSize,
  input  logic [arb_pkg::ADDR_W*NUM_CORES-1:0] coreAddr,
  input  logic [arb_pkg::DATA_W*NUM_CORES-1:0] coreWdata,
  output logic [NUM_CORES-1:0]                 coreDone,
  output logic [arb_pkg::DATA_W-1:0]           coreRdata
);
  localparam int IDX_W = $clog2(NUM_CORES);

  arb_pkg::memStrobe_t strobe;
  logic [IDX_W-1:0]    ownerIdx;

  arb_slot_ctrl #(.NUM_CORES(NUM_CORES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .coreReq  (coreReq),
    .coreWe   (coreWe),
    .ownerIdx (ownerIdx),
    .strobe   (strobe),
    .coreDone (coreDone)
  );

  arb_mem_datapath #(.NUM_CORES(NUM_CORES), .RAM_BYTES(RAM_BYTES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .ownerIdx  (ownerIdx),
    .coreSize  (coreSize),
    .coreAddr  (coreAddr),
    .coreWdata (coreWdata),
    .coreRdata (coreRdata)
  );
endmodule

// File: tb/tb_rr_mem_arbiter.sv
module tb_rr_mem_arbiter;
  localparam int NC   = 8;
  localparam int AW   = 16;
  localparam int DW   = 32;
  localparam int RAMB = 4096;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rstN;
  logic [NC-1:0]     req, we;
  logic [2*NC-1:0]   size;
  logic [AW*NC-1:0]  addr;
  logic [DW*NC-1:0]  wdata;
  logic [NC-1:0]     done;
  logic [DW-1:0]     rdata;

  rr_mem_arbiter #(.NUM_CORES(NC), .RAM_BYTES(RAMB)) dut (
    .clk(clk), .rstN(rstN), .coreReq(req), .coreWe(we), .coreSize(size),
    .coreAddr(addr), .coreWdata(wdata), .coreDone(done), .coreRdata(rdata)
  );

  typedef struct {
    bit        w;
    bit [1:0]  sz;
    bit [15:0] a;
    bit [31:0] d;
    int        gap;
  } op_t;

  op_t       q[NC][$];
  op_t       cur[NC];
  logic [7:0] ramM [RAMB];
  int checks = 0;
  int fails  = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] romByte(input bit [15:0] a);
    return a[7:0] ^ a[15:8];
  endfunction

  // behavioural memory model from R6..R11
  task automatic modelAccess(input op_t o, output logic [31:0] rd, output string tag);
    bit [15:0] base;
    int nb;
    nb   = (o.sz == 0) ? 1 : (o.sz == 1) ? 2 : 4;
    base = (o.sz == 0) ? o.a : (o.sz == 1) ? (o.a & 16'hFFFE) : (o.a & 16'hFFFC);
    rd   = '0;
    for (int k = 0; k < nb; k++) begin
      bit [15:0] ba;
      ba = base + 16'(k);
      if (o.w) begin
        if (!ba[15]) ramM[ba % RAMB] = o.d[8*k +: 8];
      end else begin
        rd[8*k +: 8] = ba[15] ? romByte(ba) : ramM[ba % RAMB];
      end
    end
    if (o.w)                          tag = base[15] ? "R9 rom write" : "R11 write data";
    else if (base[15])                tag = "R8 rom read";
    else if (o.a >= RAMB)             tag = "R10 alias read";
    else if (base != o.a)             tag = "R7 aligned read";
    else                              tag = "R6 read";
  endtask

  function automatic op_t mk(bit w, bit [1:0] sz, bit [15:0] a, bit [31:0] d, int gap);
    op_t o;
    o.w = w; o.sz = sz; o.a = a; o.d = d; o.gap = gap;
    return o;
  endfunction

  initial begin : wdog
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int        waitCnt[NC];
    bit        busy[NC];
    int        issueCyc[NC], issueSlot[NC], lastDone[NC];
    bit        b2b[NC];
    logic [NC-1:0] expDone;
    logic [31:0]   expRdata;
    string     expTag;
    int        modelSlot, cyc;

    req = '0; we = '0; size = '0; addr = '0; wdata = '0; rstN = 1'b0;

    // preload: all cores fill the RAM with zero gaps (R5, R12)
    for (int c = 0; c < NC; c++)
      for (int j = 0; j < RAMB / 4 / NC; j++) begin
        int idx;
        idx = c * (RAMB / 4 / NC) + j;
        q[c].push_back(mk(1, 2'd2, 16'(idx * 4), 32'hA500_0000 ^ (32'(idx) * 32'h0101_0101), 0));
      end
    // directed: sizes, alignment, rom, aliasing (R6..R11)
    q[0].push_back(mk(1, 2'd2, 16'h0010, 32'h1122_3344, 0));
    q[0].push_back(mk(0, 2'd0, 16'h0013, 0, 3));
    q[0].push_back(mk(0, 2'd1, 16'h0013, 0, 0));
    q[0].push_back(mk(0, 2'd2, 16'h0011, 0, 5));
    q[0].push_back(mk(0, 2'd3, 16'h0012, 0, 0));
    q[0].push_back(mk(1, 2'd2, 16'h8010, 32'hDEAD_BEEF, 0));
    q[0].push_back(mk(0, 2'd2, 16'h8010, 0, 0));
    q[0].push_back(mk(1, 2'd0, 16'h0015, 32'h0000_00AB, 7));
    q[0].push_back(mk(0, 2'd0, 16'h1015, 0, 0));
    q[0].push_back(mk(1, 2'd1, 16'h1022, 32'h0000_BEEF, 2));
    q[0].push_back(mk(0, 2'd2, 16'h0020, 0, 0));
    for (int k = 0; k < 4; k++) q[3].push_back(mk(0, 2'd2, 16'(16'hC000 + 16'(k * 4)), 0, 0));
    // random phase: arbitrary gaps put requests at every phase (R4, R12)
    for (int c = 0; c < NC; c++)
      for (int k = 0; k < 14; k++) begin
        int r;
        bit [15:0] a;
        r = $urandom_range(0, 2);
        a = (r == 0) ? 16'($urandom_range(0, 16'h0FFF)) :
            (r == 1) ? 16'($urandom_range(16'h1000, 16'h7FFF)) :
                       16'($urandom_range(16'h8000, 16'hFFFF));
        q[c].push_back(mk(bit'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), a,
                          $urandom, $urandom_range(0, 20)));
      end

    for (int c = 0; c < NC; c++) begin
      busy[c] = 0; waitCnt[c] = q[c][0].gap; lastDone[c] = -100; b2b[c] = 0;
    end

    repeat (4) @(negedge clk) begin
      check("R1 done during reset", 32'(done), 32'd0);
      check("R1 rdata during reset", rdata, 32'd0);
    end

    @(negedge clk);
    rstN = 1'b1;
    expDone = '0; expRdata = '0; expTag = "R1 rdata after reset";
    modelSlot = 0; cyc = 0;

    forever begin
      bit allIdle;
      check("R2/R3 done vector", 32'(done), 32'(expDone));
      check(expTag, rdata, expRdata);

      for (int c = 0; c < NC; c++)
        if (expDone[c]) begin
          check("R4/R12 latency", 32'(cyc - issueCyc[c]),
                32'(((2 * c - issueSlot[c]) & 15) + 1));
          if (b2b[c]) check("R5 back-to-back spacing", 32'(cyc - lastDone[c]), 32'd16);
          busy[c] = 0; lastDone[c] = cyc;
          req[c] = 1'b0;
          waitCnt[c] = (q[c].size() > 0) ? q[c][0].gap : 0;
        end

      for (int c = 0; c < NC; c++)
        if (!busy[c] && q[c].size() > 0) begin
          if (waitCnt[c] > 0) waitCnt[c]--;
          else begin
            cur[c] = q[c].pop_front();
            b2b[c] = (cur[c].gap == 0) && (lastDone[c] == cyc);
            busy[c] = 1; issueCyc[c] = cyc; issueSlot[c] = modelSlot;
            req[c] = 1'b1; we[c] = cur[c].w;
            size[2*c +: 2] = cur[c].sz;
            addr[AW*c +: AW] = cur[c].a;
            wdata[DW*c +: DW] = cur[c].d;
          end
        end

      allIdle = 1;
      for (int c = 0; c < NC; c++) if (busy[c] || q[c].size() > 0) allIdle = 0;
      if (allIdle) break;
      if (cyc > 30000) begin
        fails++;
        $display("FAIL watchdog: requests not drained");
        break;
      end

      expDone = '0;
      if ((modelSlot & 1) == 0 && req[modelSlot >> 1]) begin
        logic [31:0] rd;
        modelAccess(cur[modelSlot >> 1], rd, expTag);
        expDone[modelSlot >> 1] = 1'b1;
        expRdata = rd;
      end
      modelSlot = (modelSlot + 1) & 15;
      @(negedge clk);
      cyc++;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule